// File: doc/BRIEF.md
# Clock Start-up Delay Sequencer

This block decides when the system clock may be handed to the core after a reset or after waking from a deep sleep mode. The source select and start-up select codes are fixed during operation. From them the block chooses an oscillator settling count and, on the reset path only, a fixed run of clock cycles followed by an optional millisecond delay. The millisecond delay is measured in pulses of a free-running 1 ms timebase input. While the sequence runs, the block holds the core in reset. It raises a clock-ready flag once the selected source can be trusted.

When the internal RC source drives the on-chip PLL, clock-ready also waits for the lock report. It drops in the same cycle that lock is lost. A sleep request from the running state turns off the RC source and the PLL. A later wake request runs only the settling count before clock-ready returns. The core reset stays released across sleep. A reserved or unknown code pair raises an error flag. The sequence then stays parked with clock-ready low and the core in reset.

Top module: `clk_startup_seq`

## Requirements
- R1: While `rstN` is low, `clkReady` and `coreRstN` are low.
- R2: Source codes are 4'b0011 (internal RC feeding the PLL), 4'b0101 (external crystal oscillator) and 4'b0001 (external clock). Any other `srcSel`, or 4'b0001 with `sutSel`=2'b11, sets `cfgError` high while the sequencer waits in its idle state. Clock-ready and `coreRstN` then stay low. A legal pair gives `cfgError` low.
- R3: Settling count N in clock cycles. For the RC source, `sutSel` 2'b11 gives SETTLE_LONG (default 16384) and every other code gives SETTLE_SHORT (default 1024). For the external oscillator, `sutSel[1]`=1 gives SETTLE_LONG and 0 gives SETTLE_SHORT. For the external clock, N is 0.
- R4: On the reset path, RST_CYCLES (default 14) clock cycles follow the settling count.
- R5: Extra millisecond ticks M on the reset path. For RC: 00→0, 01→EXTRA_SHORT (4), 10→EXTRA_LONG (64), 11→0. For the external oscillator: 00→0, 01→4, 10→4, 11→64. For the external clock: 00→0, 01→4, 10→64. Only `msTick` pulses sampled after the RST_CYCLES run count toward M.
- R6: Let edge 0 be the first rising clock edge with `rstN` high. With M=0, `clkReady` (with no lock wait) is high after edge N+14. With M>0, it is high after edge t+1, where t is the edge that samples the M-th counted `msTick`.
- R7: After a wake request sampled at edge w, `clkReady` is high after edge w+N. No RST_CYCLES run and no millisecond delay are added.
- R8: One edge after `sleepReq` is sampled in the running state, `oscRun`, `pllRun` and `clkReady` are low and `coreRstN` stays high. This holds until `wakeReq` is sampled.
- R9: When the RC source is selected and `pllEnable` is high, `clkReady` requires `pllLock`. It falls in the same cycle that `pllLock` falls. After that it rises one edge after `pllLock` is sampled high again.
- R10: `pllRun` equals `pllEnable` outside sleep.
- R11: `coreRstN` rises at the edge that ends the reset-path delay and stays high until `rstN` falls. It does not wait for PLL lock.
- R12: The delay counter never decrements below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that the sequencer counts |
| rstN | input | 1 | Asynchronous active-low reset that starts the reset path |
| msTick | input | 1 | One-cycle pulse from a free-running 1 ms timebase |
| srcSel | input | 4 | Clock source select code |
| sutSel | input | 2 | Start-up time select code |
| pllEnable | input | 1 | PLL enable bit |
| pllLock | input | 1 | PLL lock report |
| sleepReq | input | 1 | Request to enter power-down or standby |
| wakeReq | input | 1 | Wake-up event from sleep |
| clkReady | output | 1 | System clock may be released to the core |
| coreRstN | output | 1 | Active-low core reset, held until the reset-path delay ends |
| cfgError | output | 1 | Reserved or unknown code pair |
| oscRun | output | 1 | Internal RC source enable |
| pllRun | output | 1 | PLL enable after sleep gating |

## Verification
The ready time depends on the code pair, so the bench works out the due edge for each legal pair from the settling count, the 14-cycle run and the tick schedule it generates itself. It then records the first edge after which `clkReady` and `coreRstN` read high. Each value is read half a cycle after the edge that moves the state, and the recorded edge must match exactly. The lock-drop response is combinational, so it is read one time step after `pllLock` changes, before any edge. Wake timing is counted from the edge that samples the wake request, with ticks still running to show that they are ignored.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

  localparam logic [3:0] SRC_RC   = 4'b0011;
  localparam logic [3:0] SRC_XOSC = 4'b0101;
  localparam logic [3:0] SRC_XCLK = 4'b0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_RST_DLY,
    ST_WAIT_LOCK,
    ST_READY,
    ST_SLEEP
  } seqState_t;

  typedef enum logic [1:0] {
    LEN_NONE,
    LEN_SHORT,
    LEN_LONG
  } lenKind_t;

  typedef struct packed {
    logic     valid;
    logic     isRc;
    lenKind_t settle;
    lenKind_t extra;
  } cfgInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic loadSettle;
    logic loadRst;
    logic loadExtra;
    logic decCycle;
    logic decTick;
  } cntCmd_t;

  function automatic cfgInfo_t decodeCfg(input logic [3:0] src, input logic [1:0] sut);
    cfgInfo_t info;
    info.valid  = 1'b0;
    info.isRc   = 1'b0;
    info.settle = LEN_NONE;
    info.extra  = LEN_NONE;
    case (src)
      SRC_RC: begin
        info.valid  = 1'b1;
        info.isRc   = 1'b1;
        info.settle = (sut == 2'b11) ? LEN_LONG : LEN_SHORT;
        case (sut)
          2'b01:   info.extra = LEN_SHORT;
          2'b10:   info.extra = LEN_LONG;
          default: info.extra = LEN_NONE;
        endcase
      end
      SRC_XOSC: begin
        info.valid  = 1'b1;
        info.settle = sut[1] ? LEN_LONG : LEN_SHORT;
        case (sut)
          2'b00:   info.extra = LEN_NONE;
          2'b11:   info.extra = LEN_LONG;
          default: info.extra = LEN_SHORT;
        endcase
      end
      SRC_XCLK: begin
        info.valid  = (sut != 2'b11);
        info.settle = LEN_NONE;
        case (sut)
          2'b01:   info.extra = LEN_SHORT;
          2'b10:   info.extra = LEN_LONG;
          default: info.extra = LEN_NONE;
        endcase
      end
      default: info.valid = 1'b0;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/clk_seq_datapath.sv
module clk_seq_datapath
  import clk_seq_pkg::*;
#(
  parameter int SETTLE_SHORT = 1024,
  parameter int SETTLE_LONG  = 16384,
  parameter int RST_CYCLES   = 14,
  parameter int EXTRA_SHORT  = 4,
  parameter int EXTRA_LONG   = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] srcSel,
  input  logic [1:0] sutSel,
  input  logic       msTick,
  input  cntCmd_t    cmd,
  output cfgInfo_t   info,
  output logic       cntZero
);

  localparam int MAX_A = (SETTLE_LONG > SETTLE_SHORT) ? SETTLE_LONG : SETTLE_SHORT;
  localparam int MAX_B = (EXTRA_LONG > EXTRA_SHORT) ? EXTRA_LONG : EXTRA_SHORT;
  localparam int MAX_C = (RST_CYCLES > MAX_B) ? RST_CYCLES : MAX_B;
  localparam int MAX_LEN = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CW = $clog2(MAX_LEN + 1);

  logic [3:0]    cfgSrc;
  logic [1:0]    cfgSut;
  cfgInfo_t      liveInfo;
  cfgInfo_t      heldInfo;
  logic [CW-1:0] cnt;
  logic [CW-1:0] settleLen;
  logic [CW-1:0] extraLen;

  assign liveInfo = decodeCfg(srcSel, sutSel);
  assign heldInfo = decodeCfg(cfgSrc, cfgSut);
  assign info     = cmd.latchCfg ? liveInfo : heldInfo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSrc <= '0;
      cfgSut <= '0;
    end else if (cmd.latchCfg) begin
      cfgSrc <= srcSel;
      cfgSut <= sutSel;
    end
  end

  always_comb begin
    case (info.settle)
      LEN_LONG:  settleLen = CW'(SETTLE_LONG - 1);
      LEN_SHORT: settleLen = CW'(SETTLE_SHORT - 1);
      default:   settleLen = '0;
    endcase
    case (info.extra)
      LEN_LONG:  extraLen = CW'(EXTRA_LONG);
      LEN_SHORT: extraLen = CW'(EXTRA_SHORT);
      default:   extraLen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.loadSettle) begin
      cnt <= settleLen;
    end else if (cmd.loadRst) begin
      cnt <= CW'(RST_CYCLES - 1);
    end else if (cmd.loadExtra) begin
      cnt <= extraLen;
    end else if (cmd.decCycle || (cmd.decTick && msTick)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.decCycle || cmd.decTick) |-> !cntZero);

  p_tick_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.decTick && !msTick) |=> $stable(cnt));

endmodule

// File: rtl/clk_seq_ctrl.sv
module clk_seq_ctrl
  import clk_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  cfgInfo_t info,
  input  logic     cntZero,
  input  logic     pllEnable,
  input  logic     pllLock,
  input  logic     sleepReq,
  input  logic     wakeReq,
  output cntCmd_t  cmd,
  output logic     clkReady,
  output logic     coreRstN,
  output logic     cfgError,
  output logic     oscRun,
  output logic     pllRun
);

  seqState_t state, nxtState;
  logic      extraPhase, nxtPhase;
  logic      fromReset, nxtFrom;
  logic      coreRelQ;
  logic      goDone;
  logic      lockOk;

  assign lockOk = !(info.isRc && pllEnable) || pllLock;

  always_comb begin
    cmd      = '0;
    nxtState = state;
    nxtPhase = extraPhase;
    nxtFrom  = fromReset;
    goDone   = 1'b0;
    case (state)
      ST_IDLE: begin
        cmd.latchCfg = 1'b1;
        if (info.valid) begin
          nxtFrom = 1'b1;
          if (info.settle == LEN_NONE) begin
            cmd.loadRst = 1'b1;
            nxtPhase    = 1'b0;
            nxtState    = ST_RST_DLY;
          end else begin
            cmd.loadSettle = 1'b1;
            nxtState       = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (!cntZero) begin
          cmd.decCycle = 1'b1;
        end else if (fromReset) begin
          cmd.loadRst = 1'b1;
          nxtPhase    = 1'b0;
          nxtState    = ST_RST_DLY;
        end else begin
          goDone = 1'b1;
        end
      end
      ST_RST_DLY: begin
        if (!extraPhase) begin
          if (!cntZero) begin
            cmd.decCycle = 1'b1;
          end else if (info.extra != LEN_NONE) begin
            cmd.loadExtra = 1'b1;
            nxtPhase      = 1'b1;
          end else begin
            goDone = 1'b1;
          end
        end else if (!cntZero) begin
          cmd.decTick = 1'b1;
        end else begin
          goDone = 1'b1;
        end
      end
      ST_WAIT_LOCK: begin
        if (sleepReq)    nxtState = ST_SLEEP;
        else if (lockOk) nxtState = ST_READY;
      end
      ST_READY: begin
        if (sleepReq)     nxtState = ST_SLEEP;
        else if (!lockOk) nxtState = ST_WAIT_LOCK;
      end
      ST_SLEEP: begin
        if (wakeReq) begin
          nxtFrom = 1'b0;
          if (info.settle == LEN_NONE) begin
            goDone = 1'b1;
          end else begin
            cmd.loadSettle = 1'b1;
            nxtState       = ST_SETTLE;
          end
        end
      end
      default: nxtState = ST_IDLE;
    endcase
    if (goDone) begin
      nxtState = lockOk ? ST_READY : ST_WAIT_LOCK;
      nxtPhase = 1'b0;
      nxtFrom  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      extraPhase <= 1'b0;
      fromReset  <= 1'b1;
      coreRelQ   <= 1'b0;
    end else begin
      state      <= nxtState;
      extraPhase <= nxtPhase;
      fromReset  <= nxtFrom;
      coreRelQ   <= coreRelQ | goDone;
    end
  end

  assign clkReady = (state == ST_READY) && lockOk;
  assign coreRstN = coreRelQ;
  assign cfgError = (state == ST_IDLE) && !info.valid;
  assign oscRun   = (state != ST_SLEEP);
  assign pllRun   = pllEnable && (state != ST_SLEEP);

  p_core_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkReady) |-> coreRstN);

  p_core_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    coreRstN |=> coreRstN);

  p_err_holds_rst_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> !coreRstN);

  p_sleep_stays_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !wakeReq) |=> (state == ST_SLEEP && !clkReady && !pllRun));

endmodule

// File: rtl/clk_startup_seq.sv
module clk_startup_seq
  import clk_seq_pkg::*;
#(
  parameter int SETTLE_SHORT = 1024,
  parameter int SETTLE_LONG  = 16384,
  parameter int RST_CYCLES   = 14,
  parameter int EXTRA_SHORT  = 4,
  parameter int EXTRA_LONG   = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic [3:0] srcSel,
  input  logic [1:0] sutSel,
  input  logic       pllEnable,
  input  logic       pllLock,
  input  logic       sleepReq,
  input  logic       wakeReq,
  output logic       clkReady,
  output logic       coreRstN,
  output logic       cfgError,
  output logic       oscRun,
  output logic       pllRun
);

  cntCmd_t  cmd;
  cfgInfo_t info;
  logic     cntZero;

  clk_seq_datapath #(
    .SETTLE_SHORT(SETTLE_SHORT),
    .SETTLE_LONG (SETTLE_LONG),
    .RST_CYCLES  (RST_CYCLES),
    .EXTRA_SHORT (EXTRA_SHORT),
    .EXTRA_LONG  (EXTRA_LONG)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcSel (srcSel),
    .sutSel (sutSel),
    .msTick (msTick),
    .cmd    (cmd),
    .info   (info),
    .cntZero(cntZero)
  );

  clk_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .info     (info),
    .cntZero  (cntZero),
    .pllEnable(pllEnable),
    .pllLock  (pllLock),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .cmd      (cmd),
    .clkReady (clkReady),
    .coreRstN (coreRstN),
    .cfgError (cfgError),
    .oscRun   (oscRun),
    .pllRun   (pllRun)
  );

endmodule

// File: tb/clk_startup_seq_tb.sv
module clk_startup_seq_tb;

  localparam int SH  = 1024;
  localparam int LG  = 16384;
  localparam int TP  = 4;   // tick period in clock cycles
  localparam int NV  = 11;

  localparam logic [3:0] V_SRC [NV] = '{4'b0011, 4'b0011, 4'b0011, 4'b0011,
                                        4'b0101, 4'b0101, 4'b0101, 4'b0101,
                                        4'b0001, 4'b0001, 4'b0001};
  localparam logic [1:0] V_SUT [NV] = '{2'b00, 2'b01, 2'b10, 2'b11,
                                        2'b00, 2'b01, 2'b10, 2'b11,
                                        2'b00, 2'b01, 2'b10};
  localparam int V_SET [NV] = '{SH, SH, SH, LG, SH, SH, LG, LG, 0, 0, 0};
  localparam int V_EXT [NV] = '{0, 4, 64, 0, 0, 4, 4, 64, 0, 4, 64};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic [3:0] srcSel = 4'b0011;
  logic [1:0] sutSel = 2'b00;
  logic pllEnable = 1'b0, pllLock = 1'b0, sleepReq = 1'b0, wakeReq = 1'b0;
  logic clkReady, coreRstN, cfgError, oscRun, pllRun;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clk_startup_seq u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .srcSel(srcSel), .sutSel(sutSel),
    .pllEnable(pllEnable), .pllLock(pllLock), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .clkReady(clkReady), .coreRstN(coreRstN), .cfgError(cfgError),
    .oscRun(oscRun), .pllRun(pllRun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000 && !done) begin
      check(1'b0, "watchdog", cycles, 180000);
      finishRun();
    end
  end

  function automatic int expReady(input int s, input int m);
    int e, n;
    if (m == 0) return s + 14;
    n = 0;
    e = s + 14;
    while (n < m) begin
      e++;
      if (e % TP == TP - 1) n++;
    end
    return e + 1;
  endfunction

  // Walk span edges with ticks running; report first edges where outputs read high.
  task automatic walk(input int span, output int rdyEdge, output int coreEdge);
    rdyEdge = -1;
    coreEdge = -1;
    for (int e = 0; e <= span; e++) begin
      msTick = (e % TP == TP - 1);
      @(posedge clk);
      @(negedge clk);
      wakeReq = 1'b0;
      if (clkReady && rdyEdge < 0) rdyEdge = e;
      if (coreRstN && coreEdge < 0) coreEdge = e;
    end
    msTick = 1'b0;
  endtask

  task automatic applyReset(input logic [3:0] s, input logic [1:0] u);
    rstN = 1'b0;
    srcSel = s;
    sutSel = u;
    repeat (3) @(negedge clk);
    check(!clkReady && !coreRstN, "R1 reset state", {clkReady, coreRstN}, 0);
    rstN = 1'b1;
    #1;
  endtask

  task automatic goSleep();
    sleepReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sleepReq = 1'b0;
  endtask

  initial begin
    int rdy, core, ex;
    @(negedge clk);

    // table of legal pairs on the reset path
    for (int i = 0; i < NV; i++) begin
      pllEnable = (V_SRC[i] == 4'b0011);
      pllLock = 1'b1;
      applyReset(V_SRC[i], V_SUT[i]);
      check(!cfgError, "R2 legal pair no error", cfgError, 0);
      ex = expReady(V_SET[i], V_EXT[i]);
      walk(ex + 3, rdy, core);
      check(rdy == ex, "R6 ready edge (R3 R4 R5)", rdy, ex);
      check(core == ex, "R11 core reset release edge", core, ex);
    end

    // reserved / unknown pairs
    applyReset(4'b0001, 2'b11);
    check(cfgError, "R2 reserved ext clock 11", cfgError, 1);
    walk(200, rdy, core);
    check(rdy < 0 && core < 0, "R2 held off", rdy, -1);
    check(cfgError, "R2 error stays", cfgError, 1);
    applyReset(4'b1111, 2'b00);
    check(cfgError, "R2 unknown source", cfgError, 1);
    walk(60, rdy, core);
    check(rdy < 0 && core < 0, "R2 unknown held off", rdy, -1);

    // PLL lock gating on RC source
    pllEnable = 1'b1;
    pllLock = 1'b0;
    applyReset(4'b0011, 2'b00);
    walk(SH + 20, rdy, core);
    check(core == SH + 14, "R11 release without lock", core, SH + 14);
    check(rdy < 0, "R9 no ready without lock", rdy, -1);
    pllLock = 1'b1;
    #1;
    check(!clkReady, "R9 lock needs an edge", clkReady, 0);
    @(posedge clk);
    @(negedge clk);
    check(clkReady, "R9 ready after lock", clkReady, 1);
    pllLock = 1'b0;
    #1;
    check(!clkReady, "R9 same-cycle drop", clkReady, 0);
    @(posedge clk);
    @(negedge clk);
    check(!clkReady, "R9 stays low", clkReady, 0);
    pllLock = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(clkReady, "R9 relock", clkReady, 1);
    pllEnable = 1'b0;
    #1;
    check(!pllRun, "R10 pll off by enable", pllRun, 0);
    pllEnable = 1'b1;
    #1;
    check(pllRun, "R10 pll on by enable", pllRun, 1);

    // sleep and wake, RC source with settling only
    goSleep();
    check(!oscRun && !pllRun && !clkReady, "R8 sleep outputs", {oscRun, pllRun, clkReady}, 0);
    check(coreRstN, "R8 core stays out of reset", coreRstN, 1);
    walk(20, rdy, core);
    check(rdy < 0 && !oscRun, "R8 sleep holds", rdy, -1);
    wakeReq = 1'b1;
    walk(SH + 4, rdy, core);
    check(rdy == SH, "R7 wake ready edge RC", rdy, SH);
    check(core == 0, "R11 core high through wake", core, 0);

    // external clock: wake with no settling count
    pllEnable = 1'b0;
    applyReset(4'b0001, 2'b10);
    ex = expReady(0, 64);
    walk(ex + 2, rdy, core);
    check(rdy == ex, "R6 ext clock long delay", rdy, ex);
    goSleep();
    check(!oscRun && !clkReady, "R8 ext clock sleep", {oscRun, clkReady}, 0);
    wakeReq = 1'b1;
    walk(4, rdy, core);
    check(rdy == 0, "R7 wake ext clock immediate", rdy, 0);

    // external oscillator long settling on wake
    applyReset(4'b0101, 2'b10);
    ex = expReady(LG, 4);
    walk(ex + 2, rdy, core);
    check(rdy == ex, "R3 ext osc long settle", rdy, ex);
    goSleep();
    wakeReq = 1'b1;
    walk(LG + 3, rdy, core);
    check(rdy == LG, "R7 wake ext osc long", rdy, LG);

    finishRun();
  end

endmodule